// File: doc/BRIEF.md
# PTP One-Step Timestamp and Correction Rewriter

This block sits in a transmit datapath and edits precision-time-protocol frames as they stream past, eight bytes per clock. Controls presented with the first word of a frame pick one edit. Insertion mode writes the exit time into an 8-byte timestamp field. Correction mode adds the residence time, and optionally an asymmetry delay, to an 8-byte correction field. Residence time is the exit time minus an ingress time that the client supplies. Each field sits at a per-frame byte offset and may cross a word boundary.

The frame's UDP checksum can also be handled in one of three ways: it can be forced to zero, left as it is, or kept valid without touching it. In the last case the frame carries two spare bytes after the UDP payload, and the block rewrites them so that the 16-bit one's-complement sum of the frame does not change. The exit time comes from an outside time source and is sampled with the first word. Frame CRC regeneration happens downstream.

The client must leave at least two idle cycles between the last word of one frame and the first word of the next. The client must also hold valid high from the first word to the last word of a frame.

Top module: `ptp_field_rewriter`

## Requirements
- R1: A word accepted on a rising edge is presented on the output, with its valid, first-word and last-word flags, after the second rising edge that follows. Byte 0 of each word is bits [63:56]. After reset the output valid is low.
- R2: When `ctl_ts_insert` is high with the first word, the 8 bytes starting at `off_ts` are replaced by `exit_time`, most significant byte first.
- R3: When `ctl_cf_update` is high with the first word, the 8 bytes at `off_cf` are read as a big-endian 64-bit value. They are replaced by that value plus (`exit_time` - `ingress_time`) plus the asymmetry term, modulo 2^64.
- R4: The asymmetry term is `asym_delay` when `ctl_asym_add` is high with the first word, and zero otherwise.
- R5: Edited fields may start at any byte lane, including ones that cross into the next word.
- R6: When `ctl_csum_zero` is high with the first word, the two bytes at `off_csum` become 0x00. `ctl_csum_zero` and `ctl_csum_fix` are never both high.
- R7: When `ctl_csum_fix` is high together with an edit mode, the two bytes at `off_pad` are rewritten. After the rewrite, the one's-complement sum of all 16-bit words of the frame equals the sum before editing. This needs even field and pad offsets and a pad that lies after the edited field.
- R8: When no edit or zeroing control is high, the frame leaves unchanged, including the pad bytes even if `ctl_csum_fix` is high.
- R9: Bytes outside the edited field, the zeroed checksum and the rewritten pad are passed unchanged.
- R10: Controls, offsets and times are sampled only with the first word of a frame. Their values on other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of frame |
| in_eop | input | 1 | Last word of frame |
| in_data | input | 64 | Input word, byte 0 in [63:56] |
| ctl_ts_insert | input | 1 | Select insertion mode |
| ctl_cf_update | input | 1 | Select correction mode |
| ctl_asym_add | input | 1 | Add asymmetry delay in correction |
| ctl_csum_zero | input | 1 | Zero the UDP checksum |
| ctl_csum_fix | input | 1 | Keep checksum valid through the pad bytes |
| off_ts | input | 16 | Byte offset of timestamp field |
| off_cf | input | 16 | Byte offset of correction field |
| off_csum | input | 16 | Byte offset of UDP checksum |
| off_pad | input | 16 | Byte offset of the two pad bytes |
| ingress_time | input | 64 | Ingress time for residence calculation |
| exit_time | input | 64 | Exit time from the time source |
| asym_delay | input | 64 | Programmed asymmetry delay |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output first word |
| out_eop | output | 1 | Output last word |
| out_data | output | 64 | Output word |

## Verification
The pad rewrite and the field edit can land in the same output word. This happens when the pad follows directly after a field whose tail has crossed into the next word, so both byte editors act in one cycle and the pad value depends on a field that finished arriving only one cycle earlier. A directed frame puts the field at lane 6 and the pad just after it. Random frames place the pad anywhere after the field. Each output frame is judged by exact byte comparison against a bench model everywhere except the pad, and by recomputing the one's-complement sum of the whole frame against the input frame.

// File: rtl/ptp_rw_pkg.sv
// Shared types and arithmetic for the one-step field rewriter.
// Assumes 16-bit one's-complement words as used by the UDP checksum.
package ptp_rw_pkg;

    // Per-frame edit selection captured with the first word.
    typedef struct packed {
        logic ins;    // overwrite timestamp field
        logic cor;    // accumulate into correction field
        logic asym;   // include asymmetry delay
        logic zero;   // clear the checksum
        logic fix;    // rewrite pad bytes to keep the sum
    } rw_mode_t;

    // One's-complement 16-bit addition with end-around carry.
    function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/ptp_rw_field_grab.sv
// Collects the original bytes of an edited field while the frame enters.
// Assumes the field lies inside the frame; bytes may come from two words.
module ptp_rw_field_grab #(
    parameter int BYTES   = 8,
    parameter int OFF_W   = 16,
    parameter int FIELD_B = 8,
    localparam int LANE_W = $clog2(BYTES),
    localparam int WIDX_W = OFF_W - LANE_W,
    localparam int FB_W   = $clog2(FIELD_B)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [WIDX_W-1:0]    widx,
    input  logic [8*BYTES-1:0]   data,
    input  logic [OFF_W-1:0]     off,
    output logic [8*FIELD_B-1:0] field_q
);
    logic [OFF_W-1:0] rel [BYTES];

    // Distance of each lane's byte from the field start.
    always_comb begin
        for (int b = 0; b < BYTES; b++)
            rel[b] = {widx, LANE_W'(b)} - off;
    end

    // Store any byte that falls inside the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (valid) begin
            for (int b = 0; b < BYTES; b++)
                if (rel[b] < OFF_W'(FIELD_B))
                    field_q[8*(FIELD_B-1-int'(rel[b][FB_W-1:0])) +: 8] <= data[8*(BYTES-1-b) +: 8];
        end
    end
endmodule

// File: rtl/ptp_rw_calc.sv
// Computes the replacement field and the compensating pad word.
// Assumes the field is 16-bit aligned relative to the pad and checksum.
module ptp_rw_calc
    import ptp_rw_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  rw_mode_t            mode,
    input  logic [TIME_W-1:0]   old_field,
    input  logic [TIME_W-1:0]   exit_t,
    input  logic [TIME_W-1:0]   ingr_t,
    input  logic [TIME_W-1:0]   asym_val,
    input  logic [15:0]         pad_old,
    output logic [TIME_W-1:0]   new_field,
    output logic [15:0]         pad_new
);
    localparam int NWORD = TIME_W / 16;

    logic [TIME_W-1:0] asym_term;
    logic [15:0]       adj;

    // New field value for the selected mode.
    always_comb begin
        asym_term = mode.asym ? asym_val : '0;
        new_field = mode.ins ? exit_t : old_field + (exit_t - ingr_t) + asym_term;
    end

    // Pad delta: add old words, subtract new words in one's complement.
    always_comb begin
        adj = '0;
        for (int i = 0; i < NWORD; i++) begin
            adj = oc_add16(adj, old_field[16*i +: 16]);
            adj = oc_add16(adj, ~new_field[16*i +: 16]);
        end
        pad_new = oc_add16(pad_old, adj);
    end
endmodule

// File: rtl/ptp_rw_lane_edit.sv
// Picks the outgoing value of one byte lane from field, checksum or pad.
// Assumes field, checksum and pad regions do not overlap.
module ptp_rw_lane_edit #(
    parameter int OFF_W   = 16,
    parameter int FIELD_B = 8,
    localparam int FB_W   = $clog2(FIELD_B)
) (
    input  logic [OFF_W-1:0]     pos,
    input  logic [7:0]           byte_in,
    input  logic                 edit_en,
    input  logic [OFF_W-1:0]     foff,
    input  logic [8*FIELD_B-1:0] new_field,
    input  logic                 zero_en,
    input  logic [OFF_W-1:0]     coff,
    input  logic                 fix_en,
    input  logic [OFF_W-1:0]     poff,
    input  logic [15:0]          pad_new,
    output logic [7:0]           byte_out
);
    logic [OFF_W-1:0] rf, rc, rp;

    // Priority select among the three edit regions.
    always_comb begin
        rf = pos - foff;
        rc = pos - coff;
        rp = pos - poff;
        byte_out = byte_in;
        if (edit_en && rf < OFF_W'(FIELD_B))
            byte_out = 8'(new_field >> (8*(FIELD_B-1-int'(rf[FB_W-1:0]))));
        else if (zero_en && rc < OFF_W'(2))
            byte_out = 8'h00;
        else if (fix_en && rp < OFF_W'(2))
            byte_out = rp[0] ? pad_new[7:0] : pad_new[15:8];
    end
endmodule

// File: rtl/ptp_field_rewriter.sv
// One-step PTP field rewriter: timestamp insertion or correction update,
// with checksum zeroing or pad compensation, on an 8-byte stream.
// Assumes valid stays high within a frame and two idle cycles between frames.
module ptp_field_rewriter
    import ptp_rw_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int OFF_W      = 16,
    parameter int TIME_W     = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [8*DATA_BYTES-1:0] in_data,
    input  logic                    ctl_ts_insert,
    input  logic                    ctl_cf_update,
    input  logic                    ctl_asym_add,
    input  logic                    ctl_csum_zero,
    input  logic                    ctl_csum_fix,
    input  logic [OFF_W-1:0]        off_ts,
    input  logic [OFF_W-1:0]        off_cf,
    input  logic [OFF_W-1:0]        off_csum,
    input  logic [OFF_W-1:0]        off_pad,
    input  logic [TIME_W-1:0]       ingress_time,
    input  logic [TIME_W-1:0]       exit_time,
    input  logic [TIME_W-1:0]       asym_delay,
    output logic                    out_valid,
    output logic                    out_sop,
    output logic                    out_eop,
    output logic [8*DATA_BYTES-1:0] out_data
);
    localparam int DATA_W  = 8 * DATA_BYTES;
    localparam int LANE_W  = $clog2(DATA_BYTES);
    localparam int WIDX_W  = OFF_W - LANE_W;
    localparam int FIELD_B = TIME_W / 8;

    rw_mode_t          mode_q;
    logic [OFF_W-1:0]  foff_q, coff_q, poff_q, grab_off;
    logic [TIME_W-1:0] exit_q, ingr_q, asym_q;
    logic [WIDX_W-1:0] in_cnt, in_widx, p1_widx, p2_widx;
    logic              p1_valid, p1_sop, p1_eop, p2_valid, p2_sop, p2_eop;
    logic [DATA_W-1:0] p1_data, p2_data, edited;
    logic [TIME_W-1:0] old_field, new_field;
    logic [15:0]       pad_old, pad_new;

    assign in_widx  = in_sop ? '0 : in_cnt;
    assign grab_off = in_sop ? (ctl_ts_insert ? off_ts : off_cf) : foff_q;

    // Word counter for byte positions within the incoming frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_cnt <= '0;
        else if (in_valid) in_cnt <= in_widx + 1'b1;
    end

    // Per-frame context captured with the first word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            foff_q <= '0; coff_q <= '0; poff_q <= '0;
            exit_q <= '0; ingr_q <= '0; asym_q <= '0;
        end else if (in_valid && in_sop) begin
            mode_q <= '{ins: ctl_ts_insert, cor: ctl_cf_update, asym: ctl_asym_add,
                        zero: ctl_csum_zero, fix: ctl_csum_fix};
            foff_q <= grab_off;
            coff_q <= off_csum;
            poff_q <= off_pad;
            exit_q <= exit_time;
            ingr_q <= ingress_time;
            asym_q <= asym_delay;
        end
    end

    // Two-stage delay so a straddling field is complete before editing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {p1_valid, p1_sop, p1_eop, p2_valid, p2_sop, p2_eop} <= '0;
            p1_data <= '0; p2_data <= '0; p1_widx <= '0; p2_widx <= '0;
        end else begin
            {p1_valid, p1_sop, p1_eop} <= {in_valid, in_valid & in_sop, in_valid & in_eop};
            p1_data <= in_data;
            p1_widx <= in_widx;
            {p2_valid, p2_sop, p2_eop} <= {p1_valid, p1_sop, p1_eop};
            p2_data <= p1_data;
            p2_widx <= p1_widx;
        end
    end

    ptp_rw_field_grab #(.BYTES(DATA_BYTES), .OFF_W(OFF_W), .FIELD_B(FIELD_B)) u_grab (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .widx(in_widx),
        .data(in_data), .off(grab_off), .field_q(old_field)
    );

    // Original pad word taken from the word now being edited.
    always_comb begin
        pad_old = '0;
        for (int l = 0; l < DATA_BYTES - 1; l++)
            if (poff_q[LANE_W-1:0] == LANE_W'(l))
                pad_old = {p2_data[8*(DATA_BYTES-1-l) +: 8], p2_data[8*(DATA_BYTES-2-l) +: 8]};
    end

    ptp_rw_calc #(.TIME_W(TIME_W)) u_calc (
        .mode(mode_q), .old_field(old_field), .exit_t(exit_q), .ingr_t(ingr_q),
        .asym_val(asym_q), .pad_old(pad_old), .new_field(new_field), .pad_new(pad_new)
    );

    for (genvar l = 0; l < DATA_BYTES; l++) begin : g_lane
        ptp_rw_lane_edit #(.OFF_W(OFF_W), .FIELD_B(FIELD_B)) u_lane (
            .pos({p2_widx, LANE_W'(l)}),
            .byte_in(p2_data[8*(DATA_BYTES-1-l) +: 8]),
            .edit_en(mode_q.ins | mode_q.cor), .foff(foff_q), .new_field(new_field),
            .zero_en(mode_q.zero), .coff(coff_q),
            .fix_en(mode_q.fix & (mode_q.ins | mode_q.cor)), .poff(poff_q), .pad_new(pad_new),
            .byte_out(edited[8*(DATA_BYTES-1-l) +: 8])
        );
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {out_valid, out_sop, out_eop} <= '0;
            out_data <= '0;
        end else begin
            {out_valid, out_sop, out_eop} <= {p2_valid, p2_sop, p2_eop};
            out_data <= edited;
        end
    end
endmodule

// File: rtl/ptp_rw_checker.sv
// Protocol and timing properties of the rewriter, bound into the top.
// Assumes the default 8-byte word.
module ptp_rw_checker
    import ptp_rw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sop,
    input logic [63:0] in_data,
    input logic        ctl_csum_zero,
    input logic        ctl_csum_fix,
    input logic        out_valid,
    input logic        out_sop,
    input logic [63:0] out_data,
    input rw_mode_t    mode_q
);
    logic [1:0] since_rst;

    // Saturating count of edges since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_sop_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    assert_frame_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && in_valid && in_sop) |-> (!$past(in_valid) && !$past(in_valid, 2)));

    assert_csum_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |-> !(ctl_csum_zero && ctl_csum_fix));

    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid && !mode_q.ins && !mode_q.cor && !mode_q.zero)
        |-> (out_data == $past(in_data, 3)));
endmodule

bind ptp_field_rewriter ptp_rw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .ctl_csum_zero(ctl_csum_zero), .ctl_csum_fix(ctl_csum_fix),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .mode_q(mode_q)
);

// File: tb/ptp_field_rewriter_tb.sv
`timescale 1ns/1ps
module ptp_field_rewriter_tb;
    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [63:0] in_data = '0;
    logic c_ins = 0, c_cor = 0, c_asym = 0, c_zero = 0, c_fix = 0;
    logic [15:0] o_ts = 0, o_cf = 0, o_ck = 0, o_pad = 0;
    logic [63:0] t_ingr = 0, t_exit = 0, t_asym = 0;
    logic out_valid, out_sop, out_eop;
    logic [63:0] out_data;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, t_in = 0, t_out = 0, ocnt = 0;
    bit done = 0;
    logic [7:0] fin [256];
    logic [7:0] fexp [256];
    logic [7:0] fout [256];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptp_field_rewriter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .ctl_ts_insert(c_ins), .ctl_cf_update(c_cor), .ctl_asym_add(c_asym),
        .ctl_csum_zero(c_zero), .ctl_csum_fix(c_fix), .off_ts(o_ts), .off_cf(o_cf),
        .off_csum(o_ck), .off_pad(o_pad), .ingress_time(t_ingr), .exit_time(t_exit),
        .asym_delay(t_asym), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (out_sop) begin ocnt = 0; t_out = cyc; end
            for (int b = 0; b < 8; b++) fout[(ocnt + b) % 256] = out_data[8*(7-b) +: 8];
            ocnt += 8;
            if (out_eop) done = 1;
        end
    end

    // Watchdog: a hang counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [15:0] oc16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic logic [15:0] frame_sum(input logic [7:0] a [256], input int n);
        logic [15:0] s = 0;
        for (int i = 0; i < n; i += 2) s = oc16(s, {a[i], a[i+1]});
        return (s == 16'hFFFF) ? 16'h0000 : s;
    endfunction

    function automatic logic [63:0] rd64(input int off);
        logic [63:0] v = 0;
        for (int i = 0; i < 8; i++) v = {v[55:0], fin[off + i]};
        return v;
    endfunction

    // Send one frame with the given first-word controls, then judge the output.
    task automatic run_frame(input int nw, input bit ins, input bit cor, input bit asy,
                             input bit zer, input bit fix, input int foff, input int ck,
                             input int pad, input logic [63:0] ex, input logic [63:0] ig,
                             input logic [63:0] ad);
        int len = nw * 8;
        int nbad = 0;
        logic [63:0] nv, fa = 0, fe = 0;
        string tag;
        for (int i = 0; i < len; i++) begin fin[i] = 8'($urandom); fout[i] = 8'hxx; end
        for (int i = 0; i < 256; i++) fexp[i] = fin[i];
        if (ins) nv = ex;
        else     nv = rd64(foff) + (ex - ig) + (asy ? ad : 64'd0);
        if (ins || cor) for (int i = 0; i < 8; i++) fexp[foff + i] = nv[8*(7-i) +: 8];
        if (zer) begin fexp[ck] = 0; fexp[ck+1] = 0; end
        tag = ins ? "R2" : cor ? (asy ? "R4" : "R3") : zer ? "R6" : "R8";
        done = 0;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            in_valid = 1; in_sop = (w == 0); in_eop = (w == nw - 1);
            for (int b = 0; b < 8; b++) in_data[8*(7-b) +: 8] = fin[w*8 + b];
            if (w == 0) begin
                c_ins = ins; c_cor = cor; c_asym = asy; c_zero = zer; c_fix = fix;
                o_ts = 16'(ins ? foff : $urandom); o_cf = 16'(cor ? foff : $urandom);
                o_ck = 16'(ck); o_pad = 16'(pad); t_exit = ex; t_ingr = ig; t_asym = ad;
                t_in = cyc;
            end else begin
                // R10: disturb every sampled input on non-first words
                c_ins = 1'($urandom); c_cor = 1'($urandom); c_asym = 1'($urandom);
                c_zero = 1'($urandom); c_fix = !c_zero;
                o_ts = 16'($urandom); o_cf = 16'($urandom); o_ck = 16'($urandom); o_pad = 16'($urandom);
                t_exit = {$urandom, $urandom}; t_ingr = {$urandom, $urandom}; t_asym = {$urandom, $urandom};
            end
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; c_zero = 0; c_fix = 1'($urandom);
        while (!done) @(negedge clk);
        chk(t_out - t_in == 3, "R1 latency", longint'(t_out - t_in), 3);
        chk(ocnt == len, "R1 frame length", longint'(ocnt), longint'(len));
        for (int i = 0; i < len; i++) begin
            if (fix && (ins || cor) && (i == pad || i == pad + 1)) continue;
            if (fout[i] !== fexp[i]) begin
                if (nbad == 0) begin fa = 64'(fout[i]); fe = 64'(fexp[i]); end
                nbad++;
            end
        end
        chk(nbad == 0, {tag, " R9 R10 bytes"}, fa, fe);
        if (fix && (ins || cor))
            chk(frame_sum(fout, len) == frame_sum(fin, len), "R7 one's-complement sum",
                longint'(frame_sum(fout, len)), longint'(frame_sum(fin, len)));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        process::self().srandom(32'd1588);
        repeat (4) @(negedge clk);
        chk(out_valid == 0, "R1 reset valid", longint'(out_valid), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(out_valid == 0 && out_sop == 0, "R1 idle after reset", longint'(out_valid), 0);

        // R5: field at lane 6 crosses words; pad right after it, same output word as tail
        run_frame(6, 1, 0, 0, 0, 1, 22, 10, 30, 64'h0123_4567_89AB_CDEF, 0, 0);
        run_frame(6, 0, 1, 1, 0, 1, 22, 10, 30, 64'h10, 64'hFFFF_FFFF_0000_0000, 64'h55);
        // R3: negative residence wraps the correction value
        run_frame(7, 0, 1, 0, 0, 1, 30, 4, 48, 64'h5, 64'h9, 64'hDEAD);
        // R4: asymmetry value present but not requested
        run_frame(7, 0, 1, 0, 0, 0, 14, 2, 40, 64'h1000, 64'h0F00, 64'hFFFF_FFFF);
        // R6: zeroing in the same word as the field start
        run_frame(6, 1, 0, 0, 1, 0, 20, 18, 40, 64'hAAAA_5555_AAAA_5555, 0, 0);
        // R8: fix requested without an edit leaves pad alone
        run_frame(6, 0, 0, 0, 0, 1, 14, 4, 30, 64'h1, 64'h2, 64'h3);

        for (int n = 0; n < 300; n++) begin
            int nw = 5 + int'($urandom % 8);
            int len = nw * 8;
            int foff = 14 + 2 * int'($urandom % ((len - 24) / 2 + 1));
            int pad = foff + 8 + 2 * int'($urandom % ((len - 2 - foff - 8) / 2 + 1));
            int ck = 2 * int'($urandom % (foff / 2));
            int m = int'($urandom % 5);
            int c = int'($urandom % 3);
            run_frame(nw, m == 1, m >= 2, m == 3, c == 1, c == 2, foff, ck, pad,
                      {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule